// File: doc/BRIEF.md
# Exception and System-Control Register Unit

This block holds the system-control state a small MIPS-I style core needs at reset and on exception entry: a status word, a cause word, an exception return address and a fixed processor identity word. Out of reset it presents the boot program counter. From the first clock it also presents the exception vector that the fetch stage should redirect to.

The pipeline raises a one-cycle exception request carrying a 5-bit cause code, a branch-delay flag and the PC of the faulting instruction. On the next clock edge the cause word, the return address and the status mode/enable stack are all updated together. Software reaches the registers through a 5-bit index that serves both reads and writes, as move-to and move-from instructions would. Reads are combinational. Writes take effect at the clock edge.

Top module: `cp0_exc_unit`

## Requirements
- R1: While rst_ni is low, Status resets to 0x10600000 and both Cause and EPC reset to zero. reset_pc_o always reads 0xBFC00000.
- R2: Index 15 reads the identity value 0x00000002. A write to index 15 leaves that value unchanged.
- R3: When ram_vec_strap_i is 1 during reset, the reset Status also has bit 30 set and bit 22 cleared, which gives 0x50200000.
- R4: One edge after an exception request, Cause equals the branch-delay flag in bit 30, the previous Cause bits 10:8, and the cause code in bits 6:2. All other bits read zero.
- R5: One edge after an exception request, EPC (index 14) equals the request PC minus 4 when the branch-delay flag is 1, and equals the request PC when the flag is 0.
- R6: exc_vec_o is 0xBFC00180 while Status bit 22 is 1 and 0x80000080 while it is 0. An exception never changes it.
- R7: On exception entry, Status bits 5:2 take the old bits 3:0 and bits 1:0 become 0. Bits 31:6 stay as they were.
- R8: A write to index 12 replaces all of Status. A write to index 13 changes only Cause bits 9:8. A write to index 14 is ignored.
- R9: When an exception request and a register write occur in the same cycle, the registers take only the exception update.
- R10: Any index other than 12 to 15 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ram_vec_strap_i | input | 1 | Reset strap: enables coprocessor 2 and selects the RAM vector |
| exc_req_i | input | 1 | Exception entry request, one cycle |
| exc_code_i | input | 5 | Cause code for the exception |
| exc_bd_i | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 5 | Register index for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_idx_i |
| reset_pc_o | output | 32 | Boot program counter |
| exc_vec_o | output | 32 | Exception vector address |

## Verification
The assertions assume that the strap is held steady while reset is asserted and that an exception request lasts one cycle. They also assume the request PC is word aligned, so that the one-word backoff for delay slots is well defined. The stimulus drives each request for exactly one cycle with aligned PCs, and it changes the strap only while reset is held low. Simultaneous write and exception cycles are issued on purpose so that the priority rule gets exercised.

// File: rtl/cp0_exc_pkg.sv
package cp0_exc_pkg;
  typedef enum logic [4:0] {
    IDX_STATUS = 5'd12,
    IDX_CAUSE  = 5'd13,
    IDX_EPC    = 5'd14,
    IDX_PRID   = 5'd15
  } cp0_idx_e;

  localparam int unsigned BEV_BIT   = 22;
  localparam int unsigned CU2_BIT   = 30;
  localparam int unsigned BD_BIT    = 30;
  localparam int unsigned STACK_W   = 6;
  localparam int unsigned CODE_LSB  = 2;
endpackage

// File: rtl/cp0_status.sv
module cp0_status #(
  parameter int unsigned XLEN      = 32,
  parameter logic [XLEN-1:0] RST_VAL = 32'h1060_0000,
  parameter int unsigned BEV       = 22,
  parameter int unsigned CU2       = 30,
  parameter int unsigned STK_W     = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            strap_i,
  input  logic            exc_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] status_o
);
  localparam logic [XLEN-1:0] SET_MASK = XLEN'(1) << CU2;
  localparam logic [XLEN-1:0] CLR_MASK = XLEN'(1) << BEV;
  localparam logic [XLEN-1:0] RST_STRAP = (RST_VAL | SET_MASK) & ~CLR_MASK;

  logic [XLEN-1:0] status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (exc_i)
      // push the mode/enable stack by one pair
      status_d = {status_q[XLEN-1:STK_W], status_q[STK_W-3:0], 2'b00};
    else if (we_i)
      status_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= strap_i ? RST_STRAP : RST_VAL;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  p_stack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> (status_o[STK_W-1:0] == {$past(status_o[STK_W-3:0]), 2'b00}) &&
              (status_o[XLEN-1:STK_W] == $past(status_o[XLEN-1:STK_W])));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_i && !we_i) |=> $stable(status_o));
endmodule

// File: rtl/cp0_cause_epc.sv
module cp0_cause_epc #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned CODE_LSB = 2,
  parameter int unsigned BD_POS   = 30,
  parameter int unsigned KEEP_LSB = 8,
  parameter int unsigned KEEP_MSB = 10,
  parameter int unsigned SW_LSB   = 8,
  parameter int unsigned SW_MSB   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bd_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              we_cause_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o
);
  localparam logic [XLEN-1:0] KEEP_MASK =
    ((XLEN'(1) << (KEEP_MSB + 1)) - XLEN'(1)) & ~((XLEN'(1) << KEEP_LSB) - XLEN'(1));
  localparam logic [XLEN-1:0] SW_MASK =
    ((XLEN'(1) << (SW_MSB + 1)) - XLEN'(1)) & ~((XLEN'(1) << SW_LSB) - XLEN'(1));
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  logic [XLEN-1:0] cause_q, cause_d, epc_q, epc_d;

  always_comb begin
    cause_d = cause_q;
    epc_d   = epc_q;
    if (exc_i) begin
      cause_d = (XLEN'(bd_i) << BD_POS) | (cause_q & KEEP_MASK) |
                (XLEN'(code_i) << CODE_LSB);
      epc_d   = bd_i ? pc_i - WORD : pc_i;
    end else if (we_cause_i) begin
      cause_d = (cause_q & ~SW_MASK) | (wdata_i & SW_MASK);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else begin
      cause_q <= cause_d;
      epc_q   <= epc_d;
    end
  end

  assign cause_o = cause_q;
  assign epc_o   = epc_q;

  p_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> cause_o == ((XLEN'($past(bd_i)) << BD_POS) |
                          ($past(cause_o) & KEEP_MASK) |
                          (XLEN'($past(code_i)) << CODE_LSB)));

  p_epc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> epc_o == ($past(bd_i) ? $past(pc_i) - WORD : $past(pc_i)));

  p_epc_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_i |=> $stable(epc_o));

  p_cause_sw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_i |=> ((cause_o & ~SW_MASK) == ($past(cause_o) & ~SW_MASK)));
endmodule

// File: rtl/cp0_exc_unit.sv
module cp0_exc_unit
  import cp0_exc_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned CODE_W = 5,
  parameter logic [XLEN-1:0] RESET_PC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] VEC_ROM    = 32'hBFC0_0180,
  parameter logic [XLEN-1:0] VEC_RAM    = 32'h8000_0080,
  parameter logic [XLEN-1:0] PRID_VAL   = 32'h0000_0002,
  parameter logic [XLEN-1:0] STATUS_RST = 32'h1060_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ram_vec_strap_i,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              exc_bd_i,
  input  logic [XLEN-1:0]   exc_pc_i,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [XLEN-1:0]   reg_wdata_i,
  output logic [XLEN-1:0]   reg_rdata_o,
  output logic [XLEN-1:0]   reset_pc_o,
  output logic [XLEN-1:0]   exc_vec_o
);
  logic [XLEN-1:0] status, cause, epc;
  logic we_status, we_cause;

  assign we_status = reg_we_i && (reg_idx_i == IDX_STATUS);
  assign we_cause  = reg_we_i && (reg_idx_i == IDX_CAUSE);

  cp0_status #(
    .XLEN(XLEN), .RST_VAL(STATUS_RST), .BEV(BEV_BIT), .CU2(CU2_BIT), .STK_W(STACK_W)
  ) i_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(ram_vec_strap_i),
    .exc_i(exc_req_i), .we_i(we_status), .wdata_i(reg_wdata_i),
    .status_o(status)
  );

  cp0_cause_epc #(
    .XLEN(XLEN), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .BD_POS(BD_BIT)
  ) i_cause_epc (
    .clk_i(clk_i), .rst_ni(rst_ni), .exc_i(exc_req_i), .code_i(exc_code_i),
    .bd_i(exc_bd_i), .pc_i(exc_pc_i), .we_cause_i(we_cause),
    .wdata_i(reg_wdata_i), .cause_o(cause), .epc_o(epc)
  );

  always_comb begin
    case (reg_idx_i)
      IDX_STATUS: reg_rdata_o = status;
      IDX_CAUSE:  reg_rdata_o = cause;
      IDX_EPC:    reg_rdata_o = epc;
      IDX_PRID:   reg_rdata_o = PRID_VAL;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign reset_pc_o = RESET_PC;
  assign exc_vec_o  = status[BEV_BIT] ? VEC_ROM : VEC_RAM;

  p_vec_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_status |=> $stable(exc_vec_o));

  p_win_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && we_status) |=> (status[1:0] == 2'b00));
endmodule

// File: tb/test_cp0_exc_unit.sv
module test_cp0_exc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ram_vec_strap_i = 1'b0;
  logic        exc_req_i = 1'b0;
  logic [4:0]  exc_code_i = '0;
  logic        exc_bd_i = 1'b0;
  logic [31:0] exc_pc_i = '0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, reset_pc_o, exc_vec_o;

  cp0_exc_unit i_cp0_exc_unit (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    int          sel;   // 0 rdata, 1 vector, 2 reset pc
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  logic  smp = 1'b0;
  int    vectors = 0, miscompares = 0;
  bit    done = 1'b0;

  logic [31:0] m_status, m_cause, m_epc;

  always @(negedge clk_i) begin
    if (smp && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.sel == 0) ? reg_rdata_o : (it.sel == 1) ? exc_vec_o : reset_pc_o;
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int sel, input logic [4:0] idx,
                            input logic [31:0] exp, input string req);
    item_t it;
    @(posedge clk_i); #1;
    reg_idx_i = idx;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
    smp = 1'b1;
    @(posedge clk_i); #1;
    smp = 1'b0;
  endtask

  task automatic step(input logic we, input logic [4:0] idx, input logic [31:0] wd,
                      input logic exc, input logic [4:0] code, input logic bd,
                      input logic [31:0] pc);
    @(posedge clk_i); #1;
    reg_we_i = we; reg_idx_i = idx; reg_wdata_i = wd;
    exc_req_i = exc; exc_code_i = code; exc_bd_i = bd; exc_pc_i = pc;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0; exc_req_i = 1'b0;
    if (exc) begin
      m_cause  = (bd ? 32'h4000_0000 : 32'h0) | (m_cause & 32'h0000_0700) | ({27'd0, code} << 2);
      m_epc    = bd ? pc - 32'd4 : pc;
      m_status = {m_status[31:6], m_status[3:0], 2'b00};
    end else if (we) begin
      if (idx == 5'd12) m_status = wd;
      if (idx == 5'd13) m_cause = (m_cause & ~32'h300) | (wd & 32'h300);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_ni = 1'b0;
    ram_vec_strap_i = strap;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    m_status = strap ? 32'h5020_0000 : 32'h1060_0000;
    m_cause = '0; m_epc = '0;
  endtask

  task automatic check_all(input string req);
    expect_val(0, 5'd12, m_status, req);
    expect_val(0, 5'd13, m_cause, req);
    expect_val(0, 5'd14, m_epc, req);
  endtask

  initial begin
    do_reset(1'b0);
    // R1 reset values
    expect_val(0, 5'd12, 32'h1060_0000, "R1 status");
    expect_val(0, 5'd13, 32'h0, "R1 cause");
    expect_val(0, 5'd14, 32'h0, "R1 epc");
    expect_val(2, 5'd0, 32'hBFC0_0000, "R1 reset pc");
    expect_val(0, 5'd15, 32'h0000_0002, "R2 prid");
    expect_val(1, 5'd0, 32'hBFC0_0180, "R6 rom vector");

    // R8 status write, then R4/R5/R7 non-delay exception
    step(1'b1, 5'd12, 32'h1040_0035, 1'b0, 5'd0, 1'b0, 32'h0);
    expect_val(0, 5'd12, 32'h1040_0035, "R8 status write");
    step(1'b0, 5'd0, 32'h0, 1'b1, 5'h0C, 1'b0, 32'h8000_1000);
    expect_val(0, 5'd12, 32'h1040_0014, "R7 stack push");
    expect_val(0, 5'd13, 32'h0000_0030, "R4 cause no delay");
    expect_val(0, 5'd14, 32'h8000_1000, "R5 epc no delay");
    expect_val(1, 5'd0, 32'hBFC0_0180, "R6 vector after exception");

    // R8 cause mask, EPC read-only; R2 PRId read-only
    step(1'b1, 5'd13, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, 32'h0);
    expect_val(0, 5'd13, 32'h0000_0330, "R8 cause sw bits");
    step(1'b1, 5'd14, 32'h1234_5678, 1'b0, 5'd0, 1'b0, 32'h0);
    expect_val(0, 5'd14, 32'h8000_1000, "R8 epc ignored");
    step(1'b1, 5'd15, 32'hDEAD_BEEF, 1'b0, 5'd0, 1'b0, 32'h0);
    expect_val(0, 5'd15, 32'h0000_0002, "R2 prid write ignored");

    // R4/R5 delay-slot exception, keeps bits 9:8
    step(1'b0, 5'd0, 32'h0, 1'b1, 5'h1F, 1'b1, 32'h8000_2008);
    expect_val(0, 5'd13, 32'h4000_037C, "R4 cause delay slot");
    expect_val(0, 5'd14, 32'h8000_2004, "R5 epc delay slot");
    expect_val(0, 5'd12, 32'h1040_0010, "R7 second push");
    check_all("R4 model");

    // R6 RAM vector
    step(1'b1, 5'd12, 32'h0000_0000, 1'b0, 5'd0, 1'b0, 32'h0);
    expect_val(1, 5'd0, 32'h8000_0080, "R6 ram vector");

    // R9 exception wins over status write
    step(1'b1, 5'd12, 32'hFFFF_FFFF, 1'b1, 5'h02, 1'b0, 32'h0000_0100);
    expect_val(0, 5'd12, 32'h0000_0000, "R9 status from exception");
    expect_val(0, 5'd13, 32'h0000_0308, "R9 cause");
    expect_val(0, 5'd14, 32'h0000_0100, "R9 epc");
    // R9 exception wins over cause write
    step(1'b1, 5'd13, 32'h0000_0000, 1'b1, 5'h01, 1'b0, 32'h0000_0200);
    expect_val(0, 5'd13, 32'h0000_0304, "R9 cause write dropped");
    check_all("R9 model");

    // R10 unmapped indices
    expect_val(0, 5'd3, 32'h0, "R10 idx 3");
    expect_val(0, 5'd31, 32'h0, "R10 idx 31");

    // R3 strap reset
    do_reset(1'b1);
    expect_val(0, 5'd12, 32'h5020_0000, "R3 strap status");
    expect_val(1, 5'd0, 32'h8000_0080, "R3 strap vector");
    expect_val(2, 5'd0, 32'hBFC0_0000, "R1 reset pc strap");

    repeat (2) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule